// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block connects a clocked host to an external asynchronous static RAM of 2048 eight-bit words. The RAM's strobes are chip select, output enable and write enable, all active low. The host raises a one-cycle request with a direction flag, an 11-bit address and 8 bits of write data. It may only do so while `ready` is high. The controller then plays out the matching memory cycle. Every nanosecond limit is held as a whole number of clock cycles, taken from a clock-period parameter by rounding up.

A read holds chip select and output enable low for the access time. The word is captured into `rdata` on the last cycle of that window, and `rvalid` pulses for one clock. A write holds chip select and write enable low for a pulse long enough to cover the pulse width, the address-to-end time and the data setup. During the write, output enable stays high. The controller's own bus driver is on exactly while write enable is low. Short recovery gaps follow each cycle: a write gap that completes the minimum write cycle, and a read turnaround that lets the memory's drivers release the bus.

When idle, chip select stays high so that the memory sits in its low-power state. The pad tri-state buffer and the memory array are outside the block.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After synchronous reset, `ready`=1, `sram_ce_n`=`sram_oe_n`=`sram_we_n`=1, `sram_dq_oe`=0 and `rvalid`=0.
- R2: A request with `rnw`=1 (read) sampled while `ready`=1 drives `sram_addr`, `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 from the next cycle, for RD cycles (default 4).
- R3: The value on `sram_dq_in` in the last cycle of a read window is loaded into `rdata`. `rvalid` is high for exactly the one cycle that follows.
- R4: A request with `rnw`=0 (write) drives `sram_ce_n`=0, `sram_we_n`=0 and `sram_oe_n`=1 for WR cycles (default 3), with `sram_dq_out` equal to the write data. `sram_dq_oe` is high exactly while `sram_we_n` is low. Chip select, write enable and the driver all release at the same edge.
- R5: `sram_addr` stays constant while `sram_ce_n` is low, and `sram_dq_out` stays constant while `sram_dq_oe` is high.
- R6: `ready` goes low in the cycle after a request is accepted and returns high after the recovery period. A read keeps `ready` low for RD+TURN cycles (default 6). A write keeps it low for WR+WGAP cycles (default 4).
- R7: A request while `ready`=0 is ignored. A new memory cycle, seen as a falling `sram_ce_n`, begins only after a cycle with `ready`=1.
- R8: `sram_oe_n` is never low while `sram_dq_oe` is high. After a read, `sram_ce_n` stays high for TURN cycles (default 2) before any next cycle.
- R9: The cycle counts use ceiling division by the clock period:
  - RD = max(⌈t_access/T⌉, ⌈t_readcycle/T⌉)
  - WR = max(⌈t_pulse/T⌉, ⌈t_setup/T⌉, ⌈t_addr/T⌉)
  - WGAP = max(1, ⌈t_writecycle/T⌉ − WR)
  - TURN = max(1, ⌈t_release/T⌉)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 11 | Word address |
| wdata | input | 8 | Write data |
| ready | output | 1 | High when a request can be accepted |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | One-cycle pulse when `rdata` is updated |
| sram_addr | output | 11 | Memory address |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_in | input | 8 | Data from the memory |
| sram_dq_oe | output | 1 | Enable for the controller's data driver |

## Verification
Two functions can fall in the same clock:
- the read capture with its `rvalid` pulse, and a host request that must be rejected;
- the return of `ready` and the acceptance of the next request.

The bench provokes both by holding `req` high for many cycles while the address, data and direction change every cycle. Only the request present when `ready` is high may start a cycle. A per-cycle schedule model judges each case: it expects exactly one memory cycle for each request it accepted, the correct captured word, and no strobe movement at any other time. The bench's memory model returns a junk value before the last cycle of the read window, so a capture taken too early shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RECOVER
  } ctrl_state_t;

  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // the final cycle of a loaded phase
  assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 3,
  parameter int RD_CYC  = 4,
  parameter int WR_CYC  = 3,
  parameter int GAP_CYC = 1,
  parameter int TRN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              last,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              cap,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic              ready
);

  localparam logic [CNT_W-1:0] RD_V  = CNT_W'(RD_CYC);
  localparam logic [CNT_W-1:0] WR_V  = CNT_W'(WR_CYC);
  localparam logic [CNT_W-1:0] GAP_V = CNT_W'(GAP_CYC);
  localparam logic [CNT_W-1:0] TRN_V = CNT_W'(TRN_CYC);

  ctrl_state_t state;

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    cap      = 1'b0;
    case (state)
      ST_IDLE: if (req) begin
        load     = 1'b1;
        load_val = rnw ? RD_V : WR_V;
      end
      ST_READ: if (last) begin
        load     = 1'b1;
        load_val = TRN_V;
        cap      = 1'b1;
      end
      ST_WRITE: if (last) begin
        load     = 1'b1;
        load_val = GAP_V;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sram_addr <= '0;
      dq_out    <= '0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      ready     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (req) begin
          sram_addr <= addr;
          ce_n      <= 1'b0;
          ready     <= 1'b0;
          if (rnw) begin
            oe_n  <= 1'b0;
            state <= ST_READ;
          end else begin
            we_n   <= 1'b0;
            dq_oe  <= 1'b1;
            dq_out <= wdata;
            state  <= ST_WRITE;
          end
        end
        ST_READ: if (last) begin
          ce_n  <= 1'b1;
          oe_n  <= 1'b1;
          state <= ST_RECOVER;
        end
        ST_WRITE: if (last) begin
          // strobe and driver release on the same edge
          ce_n  <= 1'b1;
          we_n  <= 1'b1;
          dq_oe <= 1'b0;
          state <= ST_RECOVER;
        end
        ST_RECOVER: if (last) begin
          ready <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 4,
  parameter int T_ACCESS_NS = 15,
  parameter int T_RDCYC_NS  = 15,
  parameter int T_PULSE_NS  = 12,
  parameter int T_SETUP_NS  = 10,
  parameter int T_ADDR_NS   = 12,
  parameter int T_WRCYC_NS  = 15,
  parameter int T_RELEASE_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              rnw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  // R9: every limit rounded up to whole clock cycles
  localparam int RD_CYC  = imax(ns_to_cycles(T_ACCESS_NS, CLK_NS),
                                ns_to_cycles(T_RDCYC_NS, CLK_NS));
  localparam int WR_CYC  = imax(imax(ns_to_cycles(T_PULSE_NS, CLK_NS),
                                     ns_to_cycles(T_SETUP_NS, CLK_NS)),
                                ns_to_cycles(T_ADDR_NS, CLK_NS));
  localparam int WC_CYC  = ns_to_cycles(T_WRCYC_NS, CLK_NS);
  localparam int GAP_CYC = imax(1, WC_CYC - WR_CYC);
  localparam int TRN_CYC = imax(1, ns_to_cycles(T_RELEASE_NS, CLK_NS));
  localparam int MAX_CYC = imax(imax(RD_CYC, WR_CYC), imax(GAP_CYC, TRN_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             cap;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_ctrl_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .GAP_CYC (GAP_CYC),
    .TRN_CYC (TRN_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .rnw       (rnw),
    .addr      (addr),
    .wdata     (wdata),
    .last      (tmr_last),
    .load      (tmr_load),
    .load_val  (tmr_val),
    .cap       (cap),
    .sram_addr (sram_addr),
    .dq_out    (sram_dq_out),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe),
    .ready     (ready)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap    (cap),
    .dq_in  (sram_dq_in),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int MIN_WLOW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);

  logic [7:0] wlow_cnt;

  always_ff @(posedge clk) begin
    if (rst) wlow_cnt <= '0;
    else if (!sram_we_n) wlow_cnt <= (wlow_cnt == 8'hFF) ? wlow_cnt : wlow_cnt + 1'b1;
    else wlow_cnt <= '0;
  end

  assert_we_frame_R4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  assert_drv_window_R4: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe != sram_we_n);

  assert_wlow_min_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (wlow_cnt >= 8'(MIN_WLOW)));

  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

  assert_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !sram_ce_n |-> !ready);

  assert_start_from_ready_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_ce_n) |-> $past(ready));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> !sram_dq_oe);

  assert_read_turn_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |=> sram_ce_n);

endmodule

bind sram_cycle_ctrl sram_ctrl_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MIN_WLOW (WR_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ready       (ready),
  .rvalid      (rvalid),
  .sram_addr   (sram_addr),
  .sram_ce_n   (sram_ce_n),
  .sram_oe_n   (sram_oe_n),
  .sram_we_n   (sram_we_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sim_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_sram_cycle_ctrl;

  localparam int CLK_NS = 4;
  // R9: expected counts from the requirement formulas
  localparam int RD_CYC = (15 + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC = (12 + CLK_NS - 1) / CLK_NS;
  localparam int WC_CYC = (15 + CLK_NS - 1) / CLK_NS;
  localparam int GAP    = (WC_CYC - WR_CYC > 1) ? WC_CYC - WR_CYC : 1;
  localparam int TURN   = (8 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic rnw = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ready, rvalid, ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  rdata, dq_out, dq_in;
  logic [10:0] sram_addr;

  always #2 clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .rnw(rnw), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid), .sram_addr(sram_addr),
    .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_dq_out(dq_out), .sram_dq_in(dq_in), .sram_dq_oe(dq_oe)
  );

  // memory model: data only valid in the last cycle of the access window
  logic [7:0] mem [0:2047];
  int rd_age = 0;
  int starts = 0;
  logic prev_ce = 1'b1;

  assign dq_in = (!ce_n && !oe_n && we_n && rd_age >= RD_CYC - 1) ? mem[sram_addr] : 8'hE7;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2048; i++) mem[i] <= 8'(i) ^ 8'h3C;
      rd_age <= 0;
    end else begin
      rd_age <= (!ce_n && !oe_n) ? rd_age + 1 : 0;
      if (!ce_n && !we_n && dq_oe) mem[sram_addr] <= dq_out;
      if (prev_ce && !ce_n) starts <= starts + 1;
    end
    prev_ce <= ce_n;
  end

  typedef struct packed {
    logic ready, ce_n, oe_n, we_n, dq_oe, rvalid;
    logic [10:0] addr;
    logic [7:0] dq;
    logic [7:0] rdata;
  } exp_t;

  exp_t sched[$];
  exp_t cur;
  logic [7:0] ref_mem [0:2047];
  int checks = 0;
  int errs = 0;
  int accepted = 0;

  function automatic exp_t idle_e(input logic rdy);
    exp_t e;
    e = '0;
    e.ready = rdy; e.ce_n = 1; e.oe_n = 1; e.we_n = 1;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R6/R7 ready", 32'(ready), 32'(cur.ready));
    chk("R2/R4/R9 strobes ce,oe,we", {29'd0, ce_n, oe_n, we_n}, {29'd0, cur.ce_n, cur.oe_n, cur.we_n});
    chk("R4/R8 driver enable", 32'(dq_oe), 32'(cur.dq_oe));
    chk("R3 rvalid", 32'(rvalid), 32'(cur.rvalid));
    if (cur.rvalid) chk("R3 rdata", 32'(rdata), 32'(cur.rdata));
    if (!cur.ce_n) chk("R5 address", 32'(sram_addr), 32'(cur.addr));
    if (cur.dq_oe) chk("R4/R5 write data", 32'(dq_out), 32'(cur.dq));
  endtask

  task automatic step(input logic rq, input logic rw, input logic [10:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    compare();
    req = rq; rnw = rw; addr = a; wdata = d;
    if (cur.ready && rq) begin
      accepted++;
      if (rw) begin
        for (int i = 0; i < RD_CYC; i++) begin
          e = idle_e(0); e.ce_n = 0; e.oe_n = 0; e.addr = a;
          sched.push_back(e);
        end
        for (int i = 0; i < TURN; i++) begin
          e = idle_e(0);
          if (i == 0) begin e.rvalid = 1; e.rdata = ref_mem[a]; end
          sched.push_back(e);
        end
      end else begin
        ref_mem[a] = d;
        for (int i = 0; i < WR_CYC; i++) begin
          e = idle_e(0); e.ce_n = 0; e.we_n = 0; e.dq_oe = 1; e.addr = a; e.dq = d;
          sched.push_back(e);
        end
        for (int i = 0; i < GAP; i++) sched.push_back(idle_e(0));
      end
    end
    if (sched.size() == 0) cur = idle_e(1);
    else cur = sched.pop_front();
  endtask

  task automatic op(input logic rw, input logic [10:0] a, input logic [7:0] d);
    step(1, rw, a, d);
    for (int i = 0; i < 9; i++) step(0, 0, '0, '0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) ref_mem[i] = 8'(i) ^ 8'h3C;
    cur = idle_e(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 ready", 32'(ready), 32'd1);
    chk("R1 strobes", {29'd0, ce_n, oe_n, we_n}, 32'd7);
    chk("R1 driver", 32'(dq_oe), 32'd0);
    chk("R1 rvalid", 32'(rvalid), 32'd0);

    // R4: writes at both address extremes and the middle
    op(0, 11'd0, 8'h11);
    op(0, 11'd2047, 8'hEE);
    op(0, 11'h155, 8'hA5);
    // R2/R3: read back, plus an untouched word
    op(1, 11'd0, 8'h00);
    op(1, 11'd2047, 8'h00);
    op(1, 11'h155, 8'h00);
    op(1, 11'd7, 8'h00);
    // R7: request held high, fields changing every cycle
    for (int i = 0; i < 60; i++)
      step(1, (i % 3) != 0, 11'((i * 37) % 2048), 8'(i * 5 + 1));
    // back-to-back write then read of the same word
    step(1, 0, 11'h2AA, 8'h5C);
    for (int i = 0; i < 8; i++) step(1, 1, 11'h2AA, 8'hFF);
    for (int i = 0; i < 12; i++) step(0, 0, '0, '0);
    // R7: one memory cycle per accepted request
    chk("R7 cycle starts", 32'(starts), 32'(accepted));
    summary();
    $finish;
  end

endmodule